// File: doc/BRIEF.md
# Break Return Address Selector

When a debug break fires on an instruction-fetch match, the core must decide which program-counter value goes onto the stack so that execution resumes at the right place once the handler returns. This block makes that decision. It receives the address of the instruction that matched and the three addresses the core already has at hand: the next sequential instruction, the branch destination, and the address of a delayed branch that owns a delay slot. It also receives two flags that place the matched instruction relative to a delayed branch, and a mode bit for the timing of the break.

In before-execution mode, the matched instruction does not run. The return address points back at that instruction, or at the branch that owns it when it sits in a delay slot. In after-execution mode, the matched instruction runs. When the match falls on a delayed branch or its slot, the branch and its slot both complete, so the break takes effect at the first target instruction and the return address is the branch destination. Otherwise the return address is the next sequential one.

The result is registered on the clock edge at which the break is accepted. It stays unchanged until the next acceptance, so the stacking logic can read it at its own pace.

Top module: `brs_ret_sel`

## Requirements
- R1: With `mode_after`=0, `accept`=1 and `in_slot`=0, the next cycle shows `ret_addr`=`match_addr` and `exec_ok`=0. This holds whether or not `is_dbranch` is set.
- R2: With `mode_after`=0, `accept`=1 and `in_slot`=1, the next cycle shows `ret_addr`=`branch_addr` and `exec_ok`=0.
- R3: With `mode_after`=1, `accept`=1, `in_slot`=0 and `is_dbranch`=0, the next cycle shows `ret_addr`=`next_addr` and `exec_ok`=1.
- R4: With `mode_after`=1, `accept`=1 and either `in_slot` or `is_dbranch` set, the next cycle shows `ret_addr`=`target_addr` and `exec_ok`=1. The break is deferred to the branch target.
- R5: With `mode_after`=0 and both flags set, the delay-slot rule wins: `ret_addr`=`branch_addr` and `exec_ok`=0.
- R6: `ret_valid` is 1 in exactly the cycle after a cycle with `accept`=1 (reset inactive), and 0 otherwise.
- R7: In a cycle with `accept`=0, changes on the address, flag and mode inputs leave `ret_addr` and `exec_ok` unchanged on the next cycle.
- R8: A clock edge with `rst_n`=0 sets `ret_valid`, `exec_ok` and `ret_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| accept | input | 1 | A break is taken in this cycle |
| mode_after | input | 1 | 0: break before execution, 1: break after execution |
| in_slot | input | 1 | The matched instruction sits in a delay slot |
| is_dbranch | input | 1 | The matched instruction is a delayed branch |
| match_addr | input | ADDR_W | Address of the matched instruction |
| next_addr | input | ADDR_W | Next sequential instruction address |
| target_addr | input | ADDR_W | Destination of the delayed branch |
| branch_addr | input | ADDR_W | Address of the delayed branch owning the slot |
| ret_valid | output | 1 | One-cycle pulse: a new return address was captured |
| ret_addr | output | ADDR_W | Return address to be stacked |
| exec_ok | output | 1 | 1 if the matched instruction is allowed to run |

## Verification
The bench goes after the four mode-by-position cases and the illegal combination of both flags set in before mode. A design that checks the branch flag first would stack the matched address there instead of the owner branch address. In after mode it drives a match on the branch itself and a match on the slot. A selector that looked only at the slot flag would resume at the instruction after the branch and skip the target. Long runs of idle cycles with moving inputs expose an output register that loads without `accept`, or a valid flag that stays high.

// File: rtl/brs_pkg.sv
// Package for the break return address selector.
// Holds the source encoding and the number of candidate addresses.
// Assumes every user of the package indexes candidates with these constants.
package brs_pkg;

    localparam int N_SRC = 4;
    localparam int SRC_W = $clog2(N_SRC);

    localparam int SRC_MATCH  = 0;  // matched instruction itself
    localparam int SRC_OWNER  = 1;  // delayed branch owning the slot
    localparam int SRC_NEXT   = 2;  // next sequential instruction
    localparam int SRC_TARGET = 3;  // branch destination

    typedef enum logic [SRC_W-1:0] {
        PICK_MATCH  = SRC_W'(SRC_MATCH),
        PICK_OWNER  = SRC_W'(SRC_OWNER),
        PICK_NEXT   = SRC_W'(SRC_NEXT),
        PICK_TARGET = SRC_W'(SRC_TARGET)
    } brs_pick_e;

endpackage

// File: rtl/brs_classify.sv
// Classifier: turns the timing mode and the delayed-branch position flags
// into a one-hot choice of return-address source and the execute permission.
// Assumes in_slot and is_dbranch describe the matched instruction; when both
// are set in before mode the slot rule is used.
module brs_classify
    import brs_pkg::*;
(
    input  logic             mode_after,
    input  logic             in_slot,
    input  logic             is_dbranch,
    output logic [N_SRC-1:0] pick_oh,
    output logic             exec_ok
);

    brs_pick_e pick;

    // Choose the source from timing mode and branch position.
    always_comb begin
        if (!mode_after) begin
            pick = in_slot ? PICK_OWNER : PICK_MATCH;
        end else if (in_slot || is_dbranch) begin
            pick = PICK_TARGET;
        end else begin
            pick = PICK_NEXT;
        end
    end

    // Expand the choice to a one-hot vector for the AND-OR multiplexer.
    always_comb begin
        pick_oh = '0;
        pick_oh[pick] = 1'b1;
    end

    // The matched instruction runs only in after-execution mode.
    assign exec_ok = mode_after;

endmodule

// File: rtl/brs_addr_mux.sv
// One-hot AND-OR multiplexer over the candidate return addresses.
// Assumes pick_oh carries exactly one set bit.
module brs_addr_mux
    import brs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [N_SRC-1:0]             pick_oh,
    input  logic [N_SRC-1:0][ADDR_W-1:0] cand,
    output logic [ADDR_W-1:0]            sel_addr
);

    logic [N_SRC-1:0][ADDR_W-1:0] masked;

    // Gate each candidate with its select bit.
    for (genvar g = 0; g < N_SRC; g++) begin : g_mask
        assign masked[g] = cand[g] & {ADDR_W{pick_oh[g]}};
    end

    // OR the gated candidates together.
    always_comb begin
        sel_addr = '0;
        for (int i = 0; i < N_SRC; i++) begin
            sel_addr = sel_addr | masked[i];
        end
    end

endmodule

// File: rtl/brs_hold_reg.sv
// Capture register: loads the chosen address and execute flag on accept,
// holds them otherwise, and pulses valid for one cycle after a load.
// Assumes synchronous active-low reset.
module brs_hold_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic              d_exec,
    output logic              q_valid,
    output logic [ADDR_W-1:0] q_addr,
    output logic              q_exec
);

    // Load on accept, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_addr  <= '0;
            q_exec  <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) begin
                q_addr <= d_addr;
                q_exec <= d_exec;
            end
        end
    end

endmodule

// File: rtl/brs_ret_sel.sv
// Top of the break return address selector. Classifies the matched
// instruction, selects the return address among four candidates, and
// registers the result on the cycle the break is accepted.
// Assumes the address inputs are valid whenever accept is high.
module brs_ret_sel
    import brs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              mode_after,
    input  logic              in_slot,
    input  logic              is_dbranch,
    input  logic [ADDR_W-1:0] match_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic [ADDR_W-1:0] branch_addr,
    output logic              ret_valid,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              exec_ok
);

    logic [N_SRC-1:0]             pick_oh;
    logic                         exec_d;
    logic [N_SRC-1:0][ADDR_W-1:0] cand;
    logic [ADDR_W-1:0]            sel_addr;

    // Gather the candidates in the order given by the package constants.
    always_comb begin
        cand[SRC_MATCH]  = match_addr;
        cand[SRC_OWNER]  = branch_addr;
        cand[SRC_NEXT]   = next_addr;
        cand[SRC_TARGET] = target_addr;
    end

    brs_classify u_cls (
        .mode_after (mode_after),
        .in_slot    (in_slot),
        .is_dbranch (is_dbranch),
        .pick_oh    (pick_oh),
        .exec_ok    (exec_d)
    );

    brs_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
        .pick_oh  (pick_oh),
        .cand     (cand),
        .sel_addr (sel_addr)
    );

    brs_hold_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .d_addr  (sel_addr),
        .d_exec  (exec_d),
        .q_valid (ret_valid),
        .q_addr  (ret_addr),
        .q_exec  (exec_ok)
    );

endmodule

// File: rtl/brs_checker.sv
// Checker for brs_ret_sel: relates accepted breaks to the captured address,
// the execute flag and the valid pulse. Attached with bind below.
module brs_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept,
    input logic              mode_after,
    input logic              in_slot,
    input logic              is_dbranch,
    input logic [ADDR_W-1:0] match_addr,
    input logic [ADDR_W-1:0] next_addr,
    input logic [ADDR_W-1:0] target_addr,
    input logic [ADDR_W-1:0] branch_addr,
    input logic              ret_valid,
    input logic [ADDR_W-1:0] ret_addr,
    input logic              exec_ok
);

    p_before_plain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !mode_after && !in_slot |=> ret_addr == $past(match_addr) && !exec_ok);

    p_before_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !mode_after && in_slot |=> ret_addr == $past(branch_addr) && !exec_ok);

    p_after_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && mode_after && !in_slot && !is_dbranch |=> ret_addr == $past(next_addr) && exec_ok);

    p_after_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && mode_after && (in_slot || is_dbranch) |=> ret_addr == $past(target_addr) && exec_ok);

    p_both_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !mode_after && in_slot && is_dbranch |=> ret_addr == $past(branch_addr));

    p_valid_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ret_valid);

    p_valid_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !ret_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(ret_addr) && $stable(exec_ok));

    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> !ret_valid && !exec_ok && ret_addr == '0);

endmodule

bind brs_ret_sel brs_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .mode_after  (mode_after),
    .in_slot     (in_slot),
    .is_dbranch  (is_dbranch),
    .match_addr  (match_addr),
    .next_addr   (next_addr),
    .target_addr (target_addr),
    .branch_addr (branch_addr),
    .ret_valid   (ret_valid),
    .ret_addr    (ret_addr),
    .exec_ok     (exec_ok)
);

// File: tb/brs_ret_sel_tb.sv
`timescale 1ns/1ps
// Bench for brs_ret_sel: a behavioural model predicts the outputs one cycle
// after each stimulus and is compared at every falling edge.
module brs_ret_sel_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          accept = 1'b0;
    logic          mode_after = 1'b0;
    logic          in_slot = 1'b0;
    logic          is_dbranch = 1'b0;
    logic [AW-1:0] match_addr = '0;
    logic [AW-1:0] next_addr = '0;
    logic [AW-1:0] target_addr = '0;
    logic [AW-1:0] branch_addr = '0;
    logic          ret_valid;
    logic [AW-1:0] ret_addr;
    logic          exec_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state: the values expected after the next rising edge.
    bit            exp_valid = 1'b0;
    logic [AW-1:0] exp_addr = '0;
    bit            exp_exec = 1'b0;
    string         exp_tag = "R8";

    always #2.5 clk = ~clk;

    brs_ret_sel #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .mode_after(mode_after),
        .in_slot(in_slot), .is_dbranch(is_dbranch), .match_addr(match_addr),
        .next_addr(next_addr), .target_addr(target_addr), .branch_addr(branch_addr),
        .ret_valid(ret_valid), .ret_addr(ret_addr), .exec_ok(exec_ok)
    );

    task automatic compare();
        checks++;
        if (ret_valid !== exp_valid) begin
            errors++;
            $display("FAIL R6 (%s) ret_valid actual=%b expected=%b", exp_tag, ret_valid, exp_valid);
        end
        checks++;
        if (ret_addr !== exp_addr || exec_ok !== exp_exec) begin
            errors++;
            $display("FAIL %s ret_addr/exec_ok actual=%h/%b expected=%h/%b",
                     exp_tag, ret_addr, exec_ok, exp_addr, exp_exec);
        end
    endtask

    // Check the previous prediction, then apply new stimulus and predict.
    task automatic step(input bit rst, input bit acc, input bit mode, input bit slot,
                        input bit dbr, input logic [AW-1:0] m, input logic [AW-1:0] n,
                        input logic [AW-1:0] t, input logic [AW-1:0] b);
        @(negedge clk);
        compare();
        rst_n = rst; accept = acc; mode_after = mode; in_slot = slot; is_dbranch = dbr;
        match_addr = m; next_addr = n; target_addr = t; branch_addr = b;
        if (!rst) begin
            exp_valid = 0; exp_addr = '0; exp_exec = 0; exp_tag = "R8";
        end else if (acc) begin
            exp_valid = 1;
            if (!mode) begin
                exp_exec = 0;
                exp_addr = slot ? b : m;
                exp_tag  = slot ? (dbr ? "R5" : "R2") : "R1";
            end else begin
                exp_exec = 1;
                exp_addr = (slot || dbr) ? t : n;
                exp_tag  = (slot || dbr) ? "R4" : "R3";
            end
        end else begin
            exp_valid = 0; exp_tag = "R7";
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        // R8: reset held for a few cycles with inputs active.
        step(0, 1, 1, 0, 0, 32'h1111_0000, 32'h1111_0002, 32'h2222_0000, 32'h1110_FFFE);
        step(0, 0, 0, 0, 0, '0, '0, '0, '0);
        // R1 plain, R1 on the branch itself, R2 slot, R5 both flags.
        step(1, 1, 0, 0, 0, 32'h0000_1000, 32'h0000_1002, 32'h0000_5000, 32'h0000_0FFE);
        step(1, 1, 0, 0, 1, 32'h0000_2000, 32'h0000_2002, 32'h0000_6000, 32'h0000_1FFE);
        step(1, 1, 0, 1, 0, 32'h0000_3002, 32'h0000_3004, 32'h0000_7000, 32'h0000_3000);
        step(1, 1, 0, 1, 1, 32'h0000_4002, 32'h0000_4004, 32'h0000_8000, 32'h0000_4000);
        // R3 plain, R4 on branch, R4 on slot.
        step(1, 1, 1, 0, 0, 32'hA000_0010, 32'hA000_0012, 32'hB000_0000, 32'hA000_000E);
        step(1, 1, 1, 0, 1, 32'hA000_0020, 32'hA000_0022, 32'hB000_0100, 32'hA000_001E);
        step(1, 1, 1, 1, 0, 32'hA000_0032, 32'hA000_0034, 32'hB000_0200, 32'hA000_0030);
        // R7: idle cycles with moving inputs must not disturb the capture.
        step(1, 0, 0, 1, 0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8765_4321, 32'hDEAD_BEEF);
        step(1, 0, 1, 0, 1, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h5555_5555, 32'hAAAA_AAAA);
        step(1, 0, 0, 0, 0, 32'h1357_9BDF, 32'h2468_ACE0, 32'h0000_0001, 32'h8000_0000);
        // Back-to-back acceptances then mid-run reset (R8).
        step(1, 1, 1, 0, 0, 32'hC000_0000, 32'hC000_0002, 32'hD000_0000, 32'hBFFF_FFFE);
        step(1, 1, 0, 1, 0, 32'hC000_0010, 32'hC000_0012, 32'hD000_0010, 32'hC000_000E);
        step(0, 1, 0, 0, 0, 32'h1, 32'h2, 32'h3, 32'h4);
        step(1, 0, 0, 0, 0, 32'h1, 32'h2, 32'h3, 32'h4);
        // Random mix of all cases.
        for (int k = 0; k < 2000; k++) begin
            step(($urandom % 50) != 0, ($urandom % 3) == 0, $urandom % 2, $urandom % 2,
                 $urandom % 2, $urandom, $urandom, $urandom, $urandom);
        end
        step(1, 0, 0, 0, 0, '0, '0, '0, '0);
        @(negedge clk);
        compare();
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule